// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block turns one burst request into the ordered list of column addresses that a DRAM burst touches. A request carries a starting column, a burst-length code and an ordering bit, all taken from the mode settings at the moment the start strobe is seen. From the next cycle on, the block presents one column per cycle together with a valid flag. A last-beat flag marks the final column of the burst.

The burst covers an aligned block of columns whose size equals the burst length. The upper column bits stay constant for the whole burst. The low bits begin at the requested offset and either count upward with wrap-around (sequential ordering), or take the starting offset XOR the beat number (interleaved ordering). A memory controller uses the block to address each data beat of a read or write burst. A start strobe that coincides with a last beat chains the next burst with no idle cycle.

Top module: `burst_col_seq`

## Requirements
- R1: Length code 3'b001 gives a 2-beat burst, 3'b010 a 4-beat burst and 3'b011 an 8-beat burst. `valid_o` is high for exactly that many consecutive cycles, starting in the cycle after the accepted start strobe.
- R2: For a burst of N beats, column bits log2(N) and above equal those of the starting column on every beat.
- R3: With `interleave_i` = 0 at start, the in-block offset on beat k is (start offset + k) mod N. The start offset is the starting column's low log2(N) bits.
- R4: With `interleave_i` = 1 at start, the in-block offset on beat k is the start offset XOR k.
- R5: `last_o` is high on the final beat of a burst and on no other cycle.
- R6: A start strobe in the cycle where `last_o` is high is accepted. Beat 0 of the new burst appears in the next cycle, with no gap in `valid_o`.
- R7: An accepted start with any other length code (3'b000, 3'b1xx) produces no burst. It raises `err_o` for one cycle, in the cycle after the strobe.
- R8: Changes on `len_code_i`, `interleave_i` and `start_col_i` while a burst runs do not alter that burst.
- R9: A start strobe during a burst on a beat other than the last is ignored. The running burst continues unchanged and no extra burst follows.
- R10: Synchronous active-high reset clears `valid_o`, `last_o` and `err_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Burst request strobe |
| start_col_i | input | COL_W (10) | Starting column |
| len_code_i | input | 3 | Burst-length code |
| interleave_i | input | 1 | 0 sequential, 1 interleaved ordering |
| col_o | output | COL_W (10) | Column for the current beat |
| valid_o | output | 1 | Column output holds a beat |
| last_o | output | 1 | Current beat is the final one |
| err_o | output | 1 | Previous start carried a reserved length code |

## Verification
The hardest case to reach is a strobe landing exactly on the final beat. It must chain with a different length and ordering, and in a second variant it must carry a reserved code that ends the stream with an error. The stimulus reaches this case by watching `last_o` at the sampling point and asserting the next request in that very cycle. Ignored strobes, and mode inputs scrambled in the middle of a burst, are driven on chosen beats, and the columns that follow are compared against the ordering rules computed in the bench.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

    localparam int LEN_CODE_W = 3;
    localparam int OFF_W      = 3;   // offset bits for the longest burst (8)

    typedef enum logic {
        ORD_SEQ   = 1'b0,
        ORD_INTLV = 1'b1
    } order_e;

    // decoded length: ok flag plus in-block offset mask (N-1)
    typedef struct packed {
        logic             ok;
        logic [OFF_W-1:0] mask;
    } bl_info_t;

    // burst configuration captured at the start strobe
    typedef struct packed {
        order_e           order;
        logic [OFF_W-1:0] mask;
        logic [OFF_W-1:0] start_off;
    } burst_cfg_t;

    function automatic bl_info_t decode_bl(input logic [LEN_CODE_W-1:0] code);
        bl_info_t r;
        r.ok   = 1'b1;
        r.mask = '0;
        unique case (code)
            3'b001:  r.mask = 3'b001;
            3'b010:  r.mask = 3'b011;
            3'b011:  r.mask = 3'b111;
            default: r.ok   = 1'b0;
        endcase
        return r;
    endfunction

    function automatic logic [OFF_W-1:0] beat_offset(
        input order_e           ord,
        input logic [OFF_W-1:0] soff,
        input logic [OFF_W-1:0] k,
        input logic [OFF_W-1:0] mask
    );
        logic [OFF_W-1:0] r;
        if (ord == ORD_INTLV) r = (soff ^ k) & mask;
        else                  r = (soff + k) & mask;
        return r;
    endfunction

endpackage

// File: rtl/bcs_mode_decode.sv
module bcs_mode_decode
    import bcs_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic [LEN_CODE_W-1:0] len_code_i,
    input  logic                  interleave_i,
    input  logic [COL_W-1:0]      start_col_i,
    output burst_cfg_t            cfg_o,
    output logic                  reserved_o
);
    bl_info_t info;

    always_comb begin
        info            = decode_bl(len_code_i);
        reserved_o      = !info.ok;
        cfg_o.order     = interleave_i ? ORD_INTLV : ORD_SEQ;
        cfg_o.mask      = info.mask;
        cfg_o.start_off = start_col_i[OFF_W-1:0] & info.mask;
    end

endmodule

// File: rtl/bcs_beat_ctrl.sv
module bcs_beat_ctrl
    import bcs_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             reserved_i,
    input  logic [OFF_W-1:0] mask_i,     // mask of the running burst
    output logic             accept_o,
    output logic             active_o,
    output logic [OFF_W-1:0] beat_o,
    output logic             last_o,
    output logic             err_o
);
    logic             active_q;
    logic [OFF_W-1:0] beat_q;
    logic             err_q;

    assign last_o   = active_q && (beat_q == mask_i);
    assign accept_o = start_i && (!active_q || last_o);

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            beat_q   <= '0;
            err_q    <= 1'b0;
        end else begin
            err_q <= accept_o && reserved_i;
            if (accept_o) begin
                active_q <= !reserved_i;
                beat_q   <= '0;
            end else if (active_q) begin
                if (last_o) active_q <= 1'b0;
                else        beat_q   <= beat_q + 3'd1;
            end
        end
    end

    assign active_o = active_q;
    assign beat_o   = beat_q;
    assign err_o    = err_q;

    assert_last_in_burst_R5: assert property (@(posedge clk) disable iff (rst)
        last_o |-> active_o);

    assert_err_no_burst_R7: assert property (@(posedge clk) disable iff (rst)
        err_o |-> !active_o);

    assert_ignore_midburst_R9: assert property (@(posedge clk) disable iff (rst)
        (active_o && !last_o) |=> (active_o && beat_o == $past(beat_o) + 3'd1));

    assert_beat_in_block_R1: assert property (@(posedge clk) disable iff (rst)
        active_o |-> ((beat_o & ~mask_i) == '0));

endmodule

// File: rtl/bcs_col_gen.sv
module bcs_col_gen
    import bcs_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  burst_cfg_t       cfg_i,
    input  logic [COL_W-1:0] start_col_i,
    input  logic [OFF_W-1:0] beat_i,
    output logic [COL_W-1:0] col_o,
    output logic [OFF_W-1:0] mask_o,
    output order_e           order_o
);
    localparam int HI_W = COL_W - OFF_W;

    burst_cfg_t       cfg_q;
    logic [HI_W-1:0]  hi_q;
    logic [OFF_W-1:0] lo_fix_q;   // bits inside 3-bit field but above block
    logic [OFF_W-1:0] off;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q    <= '{order: ORD_SEQ, mask: '0, start_off: '0};
            hi_q     <= '0;
            lo_fix_q <= '0;
        end else if (load_i) begin
            cfg_q    <= cfg_i;
            hi_q     <= start_col_i[COL_W-1:OFF_W];
            lo_fix_q <= start_col_i[OFF_W-1:0] & ~cfg_i.mask;
        end
    end

    always_comb begin
        off   = beat_offset(cfg_q.order, cfg_q.start_off, beat_i, cfg_q.mask);
        col_o = {hi_q, lo_fix_q | off};
    end

    assign mask_o  = cfg_q.mask;
    assign order_o = cfg_q.order;

    assert_first_beat_start_R4: assert property (@(posedge clk) disable iff (rst)
        (beat_i == '0) |-> ((col_o[OFF_W-1:0] & cfg_q.mask) == cfg_q.start_off));

endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
    import bcs_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start_i,
    input  logic [COL_W-1:0]      start_col_i,
    input  logic [LEN_CODE_W-1:0] len_code_i,
    input  logic                  interleave_i,
    output logic [COL_W-1:0]      col_o,
    output logic                  valid_o,
    output logic                  last_o,
    output logic                  err_o
);
    burst_cfg_t       cfg;
    logic             reserved;
    logic             accept;
    logic             active;
    logic [OFF_W-1:0] beat;
    logic [OFF_W-1:0] mask_q;
    order_e           order_q;
    logic [COL_W-1:0] col;

    bcs_mode_decode #(.COL_W(COL_W)) u_dec (
        .len_code_i  (len_code_i),
        .interleave_i(interleave_i),
        .start_col_i (start_col_i),
        .cfg_o       (cfg),
        .reserved_o  (reserved)
    );

    bcs_beat_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start_i   (start_i),
        .reserved_i(reserved),
        .mask_i    (mask_q),
        .accept_o  (accept),
        .active_o  (active),
        .beat_o    (beat),
        .last_o    (last_o),
        .err_o     (err_o)
    );

    bcs_col_gen #(.COL_W(COL_W)) u_col (
        .clk        (clk),
        .rst        (rst),
        .load_i     (accept && !reserved),
        .cfg_i      (cfg),
        .start_col_i(start_col_i),
        .beat_i     (beat),
        .col_o      (col),
        .mask_o     (mask_q),
        .order_o    (order_q)
    );

    assign valid_o = active;
    assign col_o   = col;

    initial begin
        assert_col_width_R2: assert (COL_W > OFF_W);
    end

    assert_upper_fixed_R2: assert property (@(posedge clk) disable iff (rst)
        (valid_o && $past(valid_o) && !$past(last_o)) |-> $stable(col_o[COL_W-1:OFF_W]));

    assert_seq_step_R3: assert property (@(posedge clk) disable iff (rst)
        (valid_o && $past(valid_o) && !$past(last_o) && order_q == ORD_SEQ) |->
        ((col_o[OFF_W-1:0] & mask_q) == (($past(col_o[OFF_W-1:0]) + 3'd1) & mask_q)));

    assert_reset_quiet_R10: assert property (@(posedge clk)
        $past(rst) |-> (!valid_o && !last_o && !err_o));

endmodule

// File: tb/burst_col_seq_bench.sv
`timescale 1ns/1ps
module burst_col_seq_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_i = 1'b0;
    logic [9:0] start_col_i = '0;
    logic [2:0] len_code_i = 3'b001;
    logic       interleave_i = 1'b0;
    logic [9:0] col_o;
    logic       valid_o, last_o, err_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    burst_col_seq u_burst_col_seq (
        .clk(clk), .rst(rst), .start_i(start_i), .start_col_i(start_col_i),
        .len_code_i(len_code_i), .interleave_i(interleave_i),
        .col_o(col_o), .valid_o(valid_o), .last_o(last_o), .err_o(err_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int code_of(input int n);
        return (n == 2) ? 1 : (n == 4) ? 2 : 3;
    endfunction

    function automatic int exp_col(input int n, input bit il, input int s, input int k);
        int so, off;
        so  = s % n;
        off = il ? (so ^ k) : ((so + k) % n);
        return (s - so) + off;
    endfunction

    // drive a start at the current negedge
    task automatic drive_start(input int n, input bit il, input int s);
        start_i      = 1'b1;
        len_code_i   = 3'(code_of(n));
        interleave_i = il;
        start_col_i  = 10'(s);
    endtask

    // called at the negedge where beat 0 is visible; checks all beats
    task automatic check_beats(input int n, input bit il, input int s, input string tag);
        for (int k = 0; k < n; k++) begin
            chk(valid_o === 1'b1, {tag, " valid"}, int'(valid_o), 1);
            chk(col_o == 10'(exp_col(n, il, s, k)), tag, int'(col_o), exp_col(n, il, s, k));
            chk(last_o === (k == n - 1), "R5 last flag", int'(last_o), int'(k == n - 1));
            if (k < n - 1) @(negedge clk);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(!valid_o && !last_o && !err_o, "R10 reset", int'({valid_o, last_o, err_o}), 0);
    endtask

    task automatic t_single(input int n, input bit il, input int s, input string tag);
        drive_start(n, il, s);
        @(negedge clk);
        start_i = 1'b0;
        check_beats(n, il, s, tag);
        @(negedge clk);
        chk(valid_o === 1'b0, "R1 burst ends", int'(valid_o), 0);
    endtask

    task automatic t_chain();
        drive_start(4, 0, 'h1F6);
        @(negedge clk);
        start_i = 1'b0;
        for (int k = 0; k < 3; k++) @(negedge clk);
        chk(last_o === 1'b1, "R6 at last", int'(last_o), 1);
        drive_start(8, 1, 'h2A5);
        @(negedge clk);
        start_i = 1'b0;
        check_beats(8, 1, 'h2A5, "R6 chained interleaved");
        @(negedge clk);
        chk(valid_o === 1'b0, "R6 end", int'(valid_o), 0);
    endtask

    task automatic t_midburst();
        drive_start(8, 0, 'h133);
        @(negedge clk);
        start_i = 1'b0;
        for (int k = 0; k < 8; k++) begin
            chk(col_o == 10'(exp_col(8, 0, 'h133, k)), "R8 R9 col held", int'(col_o), exp_col(8, 0, 'h133, k));
            chk(valid_o === 1'b1, "R9 valid held", int'(valid_o), 1);
            if (k == 2) begin
                start_i = 1'b1; start_col_i = 10'h3FF; len_code_i = 3'b001; interleave_i = 1'b1;
            end else begin
                start_i = 1'b0; start_col_i = 10'(k * 37); len_code_i = 3'b111; interleave_i = k[0];
            end
            @(negedge clk);
        end
        start_i = 1'b0;
        chk(valid_o === 1'b0 && err_o === 1'b0, "R9 no extra burst", int'({valid_o, err_o}), 0);
    endtask

    task automatic t_reserved(input int code);
        start_i = 1'b1; len_code_i = 3'(code); start_col_i = 10'h055;
        @(negedge clk);
        start_i = 1'b0;
        chk(err_o === 1'b1, $sformatf("R7 err code %0d", code), int'(err_o), 1);
        chk(valid_o === 1'b0, "R7 no burst", int'(valid_o), 0);
        @(negedge clk);
        chk(err_o === 1'b0 && valid_o === 1'b0, "R7 one-cycle err", int'({err_o, valid_o}), 0);
    endtask

    task automatic t_reserved_on_last();
        drive_start(2, 0, 'h041);
        @(negedge clk);
        start_i = 1'b0;
        @(negedge clk);
        chk(last_o === 1'b1, "R7 at last", int'(last_o), 1);
        start_i = 1'b1; len_code_i = 3'b100;
        @(negedge clk);
        start_i = 1'b0;
        chk(err_o === 1'b1 && valid_o === 1'b0, "R7 reserved chain", int'({err_o, valid_o}), 2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_single(2, 0, 'h3A1, "R1 R3 len2 seq");
        t_single(4, 0, 'h0B6, "R2 R3 len4 seq start2");
        t_single(8, 0, 'h2FD, "R2 R3 len8 seq wrap");
        t_single(2, 1, 'h100, "R4 len2 intl");
        t_single(4, 1, 'h3E7, "R4 len4 intl");
        t_single(8, 1, 'h15D, "R2 R4 len8 intl start5");
        t_chain();
        t_midburst();
        t_reserved(0);
        t_reserved(4);
        t_reserved(7);
        t_reserved_on_last();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(!valid_o && !last_o && !err_o, "R10 re-reset", int'({valid_o, last_o, err_o}), 0);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #50000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule